// File: doc/BRIEF.md
# Caller ID Bit Capture Buffer

This block records the demodulated caller identification bit stream that arrives on a telephone line between the first and the second ring burst. It takes a single demodulated FSK data bit, already reduced to one bit by a comparator and demodulator upstream, and two line-state inputs. The first line-state input says that the device is in its ringing state. The second says that a ring burst is present right now. The block regenerates the 1200 baud bit timing from the system clock, samples each symbol in its middle and packs the captured bits into an on-chip store that holds up to `DEPTH_BITS` bits (4096 by default).

A host reads the captured data back as bytes through a plain address/data read port with one cycle of latency. It also sees a count of the valid bits and a flag that reports bits lost because the store was full. A clear input empties the store and drops the flag. Capture arms when the first ring burst ends. It stops when the next burst starts or when the device leaves the ringing state. Stored bits only begin at the first line transition after arming, so idle mark tone ahead of the message is not recorded.

Top module: `cid_capture`

## Requirements
- R1: Bit timing comes from a fractional accumulator that advances by twice the baud rate on every clock, so the average rate is exactly `BAUD`. Every input transition restarts the timing. The first sample is taken half a bit period after the transition, then one sample each full bit period.
- R2: At most `DEPTH_BITS` bits are stored, and `bit_count` never exceeds `DEPTH_BITS`.
- R3: Each stored bit raises `bit_count` by exactly one. No other event changes it apart from clear and reset.
- R4: Bits are stored only in the gap after a ring burst that began in the idle state, and only from the first input transition in that gap. Bits during the first burst, before any burst, or after the next burst begins are not stored.
- R5: While `ring_state` is low nothing is stored, and a fall of `ring_state` during the gap ends capture.
- R6: A bit sampled while the store is full sets `overflow` and leaves the count and the stored data unchanged.
- R7: A high `clr` makes `bit_count` zero and `overflow` low at the next clock edge.
- R8: Byte `k` returned on `rd_data` holds stored bit `8k+j` in position `j` (least significant bit first). The data is valid one clock after `rd_addr` is presented.
- R9: After reset `bit_count` is zero, `overflow` is low and the block waits for a ring burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Demodulated FSK data bit, asynchronous |
| ring_state | input | 1 | Device is in its ringing state, asynchronous |
| ring_burst | input | 1 | Ring burst energy currently present, asynchronous |
| clr | input | 1 | Empty the store and clear the overflow flag |
| rd_addr | input | log2(DEPTH_BITS/8) | Byte index for host readout |
| rd_data | output | 8 | Registered byte read from the store |
| bit_count | output | log2(DEPTH_BITS+1) | Number of valid stored bits |
| overflow | output | 1 | Bits were dropped because the store was full |

## Verification
The hardest case to reach from the ports is the exact boundary of the capture window. The bit timer keeps sampling on its own, so the last stored bit depends on where the next ring burst falls relative to the sample instants. The stimulus starts every message with a transition out of idle mark. It holds the final symbol for two bit periods and raises the next burst exactly at the end of that hold. This puts the burst midway between two samples, so the expected content is the message plus one repeat of its last bit. Symbol lengths vary by a few clocks from bit to bit, which only works if timing realigns on each edge. A message longer than the store drives the full and overflow path.

// File: rtl/cid_pkg.sv
package cid_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RING1 = 2'd1,
    ST_GAP   = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_t;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/cid_bit_timer.sv
module cid_bit_timer #(
  parameter int unsigned CLK_HZ = 48_000_000,
  parameter int unsigned BAUD   = 1200
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic edge_seen,
  output logic sample_stb,
  output logic sample_bit
);

  localparam int unsigned STEP  = 2 * BAUD;
  localparam int unsigned ACC_W = $clog2(CLK_HZ + STEP) + 1;
  localparam logic [ACC_W-1:0] LIMIT = ACC_W'(CLK_HZ);
  localparam logic [ACC_W-1:0] INC   = ACC_W'(STEP);

  logic [2:0]       rx_pipe;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] acc_sum;
  logic             phase;
  logic             rx_s;
  logic             edge_now;
  logic             half_tick;

  assign rx_s      = rx_pipe[1];
  assign edge_now  = rx_pipe[2] ^ rx_pipe[1];
  assign acc_sum   = acc + INC;
  assign half_tick = (acc_sum >= LIMIT);

  always_ff @(posedge clk) begin
    if (rst) rx_pipe <= '1;
    else     rx_pipe <= {rx_pipe[1:0], rx_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      phase      <= 1'b0;
      sample_stb <= 1'b0;
      sample_bit <= 1'b1;
      edge_seen  <= 1'b0;
    end else begin
      edge_seen  <= edge_now;
      sample_stb <= 1'b0;
      if (edge_now) begin
        acc   <= '0;
        phase <= 1'b0;
      end else if (half_tick) begin
        acc   <= acc_sum - LIMIT;
        phase <= ~phase;
        if (!phase) begin
          sample_stb <= 1'b1;
          sample_bit <= rx_s;
        end
      end else begin
        acc <= acc_sum;
      end
    end
  end

  // R1: samples are a full bit apart, never back to back
  a_r1_strobe_gap: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb);

  // R1: after a transition the next sample waits at least half a bit
  a_r1_realign: assert property (@(posedge clk) disable iff (rst)
    edge_seen |-> !sample_stb);

endmodule

// File: rtl/cid_capture_ctrl.sv
module cid_capture_ctrl
  import cid_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ring_state,
  input  logic ring_burst,
  input  logic edge_seen,
  input  logic sample_stb,
  output logic take_bit
);

  logic [1:0]  rs_pipe;
  logic [1:0]  rb_pipe;
  logic        rs_s;
  logic        rb_s;
  logic        started;
  cap_state_t  state;
  cap_state_t  state_nx;

  assign rs_s = rs_pipe[1];
  assign rb_s = rb_pipe[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rs_pipe <= '0;
      rb_pipe <= '0;
    end else begin
      rs_pipe <= {rs_pipe[0], ring_state};
      rb_pipe <= {rb_pipe[0], ring_burst};
    end
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (rs_s && rb_s) state_nx = ST_RING1;
      ST_RING1: if (!rs_s) state_nx = ST_IDLE;
                else if (!rb_s) state_nx = ST_GAP;
      ST_GAP:   if (!rs_s) state_nx = ST_IDLE;
                else if (rb_s) state_nx = ST_DONE;
      ST_DONE:  if (!rs_s) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      started <= 1'b0;
    end else begin
      state <= state_nx;
      if (state != ST_GAP)  started <= 1'b0;
      else if (edge_seen)   started <= 1'b1;
    end
  end

  assign take_bit = (state == ST_GAP) && started && sample_stb;

  // R5: leaving the ringing state always returns to idle
  a_r5_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !rs_s |=> (state == ST_IDLE));

  // R4: once the window has closed it does not reopen without going idle
  a_r4_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> (state == ST_DONE || state == ST_IDLE));

endmodule

// File: rtl/cid_bit_store.sv
module cid_bit_store
  import cid_pkg::*;
#(
  parameter int unsigned DEPTH_BITS = 4096
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              clr,
  input  logic                              take_bit,
  input  logic                              bit_in,
  input  logic [$clog2(DEPTH_BITS/8)-1:0]   rd_addr,
  output logic [BYTE_W-1:0]                 rd_data,
  output logic [$clog2(DEPTH_BITS+1)-1:0]   bit_count,
  output logic                              overflow
);

  localparam int unsigned BYTES = DEPTH_BITS / 8;
  localparam int unsigned AW    = $clog2(BYTES);
  localparam int unsigned CNT_W = $clog2(DEPTH_BITS + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH_BITS);

  logic [BYTE_W-1:0] mem [BYTES];
  logic [BYTE_W-1:0] pack_q;
  logic [BYTE_W-1:0] pack_nx;
  logic [AW-1:0]     wr_addr;
  logic [2:0]        pos;
  logic              full;
  logic              do_write;

  assign full     = (bit_count == FULL_CNT);
  assign pos      = bit_count[2:0];
  assign wr_addr  = AW'(bit_count >> 3);
  assign do_write = take_bit && !full && !clr;
  assign pack_nx  = ((pos == 3'd0) ? '0 : pack_q) | (BYTE_W'(bit_in) << pos);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bit_count <= '0;
      overflow  <= 1'b0;
      pack_q    <= '0;
    end else if (take_bit) begin
      if (full) begin
        overflow <= 1'b1;
      end else begin
        bit_count <= bit_count + CNT_W'(1);
        pack_q    <= pack_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_write) mem[wr_addr] <= pack_nx;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    bit_count <= FULL_CNT);

  a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (bit_count == $past(bit_count) ||
              bit_count == $past(bit_count) + CNT_W'(1)));

  a_r6_overflow_full: assert property (@(posedge clk) disable iff (rst)
    overflow |-> full);

  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (bit_count == '0 && !overflow));

endmodule

// File: rtl/cid_capture.sv
module cid_capture
  import cid_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 48_000_000,
  parameter int unsigned BAUD       = 1200,
  parameter int unsigned DEPTH_BITS = 4096
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rx_bit,
  input  logic                              ring_state,
  input  logic                              ring_burst,
  input  logic                              clr,
  input  logic [$clog2(DEPTH_BITS/8)-1:0]   rd_addr,
  output logic [BYTE_W-1:0]                 rd_data,
  output logic [$clog2(DEPTH_BITS+1)-1:0]   bit_count,
  output logic                              overflow
);

  logic edge_seen;
  logic sample_stb;
  logic sample_bit;
  logic take_bit;

  cid_bit_timer #(
    .CLK_HZ (CLK_HZ),
    .BAUD   (BAUD)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .rx_in      (rx_bit),
    .edge_seen  (edge_seen),
    .sample_stb (sample_stb),
    .sample_bit (sample_bit)
  );

  cid_capture_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ring_state (ring_state),
    .ring_burst (ring_burst),
    .edge_seen  (edge_seen),
    .sample_stb (sample_stb),
    .take_bit   (take_bit)
  );

  cid_bit_store #(
    .DEPTH_BITS (DEPTH_BITS)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .take_bit  (take_bit),
    .bit_in    (sample_bit),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .bit_count (bit_count),
    .overflow  (overflow)
  );

endmodule

// File: tb/cid_capture_test.sv
`timescale 1ns/1ps
module cid_capture_test;

  localparam int unsigned CLK_HZ = 24000;
  localparam int unsigned BAUD   = 1200;
  localparam int unsigned DEPTH  = 32;
  localparam logic [15:0] PAT    = 16'h65A6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit = 1'b1;
  logic       ring_state = 1'b0;
  logic       ring_burst = 1'b0;
  logic       clr = 1'b0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [5:0] bit_count;
  logic       overflow;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 1'b0;
  bit exp_bits[$];

  cid_capture #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DEPTH_BITS(DEPTH)) uut (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .ring_state(ring_state),
    .ring_burst(ring_burst), .clr(clr), .rd_addr(rd_addr),
    .rd_data(rd_data), .bit_count(bit_count), .overflow(overflow)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_count();
    return (exp_bits.size() > DEPTH) ? DEPTH : exp_bits.size();
  endfunction

  // per-clock model comparison of the bound and the overflow relation (R2, R6)
  always @(negedge clk) begin
    cycles++;
    if (!rst && !finished) begin
      chk("R2 count bound", (bit_count <= DEPTH), 1);
      if (overflow) chk("R6 overflow only when full", bit_count, DEPTH);
    end
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic noise(int n);
    for (int i = 0; i < n; i++) begin
      rx_bit = i[0] ? 1'b1 : 1'b0;
      wait_cyc(20);
    end
    rx_bit = 1'b1;
    wait_cyc(30);
  endtask

  // one capture window: first burst with noise, gap with n message bits, then stop
  task automatic run_gap(int n, bit stop_by_state);
    ring_burst = 1'b1;
    wait_cyc(10);
    noise(3);                       // R4: bits inside the first burst
    ring_burst = 1'b0;
    wait_cyc(40);                   // R4: idle mark in the gap before the first edge
    for (int i = 0; i < n; i++) begin
      bit v;
      int len;
      v   = PAT[i % 16];
      len = (i == n - 1) ? 40 : 19 + (i % 3);   // R1: jittered symbol lengths
      rx_bit = v;
      wait_cyc(len);
      exp_bits.push_back(v);
      if (i == n - 1) exp_bits.push_back(v);
    end
    if (stop_by_state) ring_state = 1'b0;
    else               ring_burst = 1'b1;
    wait_cyc(10);
    noise(4);                       // R4/R5: bits after the window closed
  endtask

  task automatic verify(string req);
    int nbytes;
    chk({req, " count"}, bit_count, exp_count());
    chk({req, " overflow"}, overflow, (exp_bits.size() > DEPTH) ? 1 : 0);
    nbytes = (exp_count() + 7) / 8;
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] eb;
      logic [7:0] mask;
      eb = '0; mask = '0;
      for (int j = 0; j < 8; j++) begin
        if (8 * k + j < exp_count()) begin
          mask[j] = 1'b1;
          eb[j]   = exp_bits[8 * k + j];
        end
      end
      rd_addr = k[1:0];
      wait_cyc(1);
      chk({"R8 ", req, " byte"}, rd_data & mask, eb);
    end
  endtask

  task automatic do_clear();
    clr = 1'b1;
    wait_cyc(1);
    clr = 1'b0;
    exp_bits.delete();
    chk("R7 cleared count", bit_count, 0);
    chk("R7 cleared overflow", overflow, 0);
  endtask

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(1);
    chk("R9 reset count", bit_count, 0);
    chk("R9 reset overflow", overflow, 0);

    // R4: ringing state but no burst yet -> nothing stored
    ring_state = 1'b1;
    wait_cyc(5);
    noise(6);
    chk("R4 before first burst", bit_count, 0);

    // R1 R3 R4 R8: window closed by the next burst
    run_gap(12, 1'b0);
    verify("R1 R3 R4 window A");
    ring_burst = 1'b0;
    ring_state = 1'b0;
    wait_cyc(10);

    // R5: bursts and bits with ring_state low are ignored
    ring_burst = 1'b1;
    wait_cyc(40);
    ring_burst = 1'b0;
    wait_cyc(40);
    noise(6);
    chk("R5 ring_state low", bit_count, exp_count());

    // R7 then R5: window closed by leaving the ringing state
    do_clear();
    ring_state = 1'b1;
    wait_cyc(5);
    run_gap(6, 1'b1);
    verify("R5 window B");

    // R2 R6: message longer than the store
    do_clear();
    ring_state = 1'b1;
    wait_cyc(5);
    run_gap(40, 1'b0);
    verify("R2 R6 overflow window");
    ring_burst = 1'b0;
    ring_state = 1'b0;
    wait_cyc(5);
    do_clear();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule